// File: doc/BRIEF.md
# Program Memory Lock and Encrypted Readout Controller

This block guards a 4 KB on-chip program store that is written and read back through a dedicated programming port. A 3-bit operation code selects one of these operations:

- program a code byte
- program a byte of a 32-entry key table
- set either of two lock bits
- verify (read back) a code byte
- read a fixed identification byte

Writes do not happen on a single strobe. A write commits only after a train of program-strobe pulses, and each pulse must meet a minimum low width and a minimum preceding high gap.

Verify data never leaves the block in the clear while a key is loaded. Each code byte is combined by XNOR with the key entry picked by the low five address bits. An erased key is all ones, so it passes data through unchanged. No operation ever returns the key table itself.

The two lock bits form a policy:

- With either bit set, code and key writes are refused, but the other lock bit can still be set.
- The first bit also denies code fetched from outside access to the internal store, and freezes the external-access strap at the level it had during the last reset.
- With both bits set, verify is disabled.

Storage and lock bits are non-volatile: reset does not touch them, and only an erase pulse returns them to all ones or unprogrammed. Any refused operation raises a sticky error flag that only reset clears.

Top module: `prom_guard`

## Requirements
- R1: After reset, `dout` is FFh and `err` is 0.
- R2: A one-cycle `uv_erase` makes every code and key byte FFh and clears both lock bits, so verify then returns FFh at every address.
- R3: A program operation commits on the 25th qualified pulse of `prog_n` while `op_sel` stays at one programming code; 24 qualified pulses change nothing.
- R4: A low pulse shorter than `LOW_MIN` cycles is not counted. A pulse whose preceding high gap is shorter than `HIGH_MIN` cycles is not counted either.
- R5: Changing `op_sel` discards a partly counted pulse train.
- R6: `op_sel`=2 (verify) returns, one cycle later, code[addr] XNOR key[addr[4:0]].
- R7: `op_sel`=3 writes key entry addr[4:0] only when addr[11:5] is zero. Otherwise the write is refused and `err` is set.
- R8: With either lock bit set, `op_sel`=1 (code) and `op_sel`=3 (key) writes are refused, the store is unchanged and `err` is set. `op_sel`=4 sets lock bit 1 and `op_sel`=5 sets lock bit 2, and both are always accepted.
- R9: With both lock bits set, verify returns FFh and sets `err`.
- R10: `op_sel`=6 returns 89h at address 030h, 57h at 031h and FFh elsewhere, one cycle later.
- R11: With lock bit 1 set, `ext_fetch_deny` is 1 and `ea_eff` holds the `ext_access` level of the last reset. Otherwise `ea_eff` follows `ext_access` and `ext_fetch_deny` is 0.
- R12: `err` stays set until reset. Reset keeps code, key and lock contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_erase | input | 1 | One-cycle erase of all storage and locks |
| op_sel | input | 3 | Operation: 0 idle, 1 code write, 2 verify, 3 key write, 4 lock 1, 5 lock 2, 6 identification read |
| addr | input | 12 | Byte address |
| din | input | 8 | Byte to program |
| prog_n | input | 1 | Active-low program strobe |
| ext_access | input | 1 | External-access strap level |
| dout | output | 8 | Registered read data |
| ea_eff | output | 1 | Effective external-access level |
| ext_fetch_deny | output | 1 | Externally fetched code may not read the internal store |
| err | output | 1 | Sticky refused-operation flag |

## Verification
The hardest case to reach is a pulse train that comes within one pulse of committing and then loses that pulse. The stimulus builds such trains:

- 24 good pulses followed by one pulse a cycle too short
- 24 good pulses where the last pulse follows a high gap that is too short
- 20 good pulses, a change of operation, then five more

Each train is followed by a verify read of the target address. Random code and key writes at seeded addresses load the store before these trains. The lock policy and the strap latch are then reached in order: set lock 1, reset at both strap levels, attempt refused writes, then set lock 2.

// File: rtl/prom_guard_pkg.sv
package prom_guard_pkg;

    localparam int PG_ADDR_W = 12;
    localparam int PG_DATA_W = 8;
    localparam int PG_KEYS   = 32;

    localparam logic [15:0] ID_ADDR_LO = 16'h0030;
    localparam logic [15:0] ID_ADDR_HI = 16'h0031;
    localparam logic [7:0]  ID_BYTE_LO = 8'h89;
    localparam logic [7:0]  ID_BYTE_HI = 8'h57;
    localparam logic [7:0]  BLANK      = 8'hFF;

    typedef enum logic [2:0] {
        OP_IDLE       = 3'd0,
        OP_PROG_CODE  = 3'd1,
        OP_VERIFY     = 3'd2,
        OP_PROG_KEY   = 3'd3,
        OP_PROG_LOCK1 = 3'd4,
        OP_PROG_LOCK2 = 3'd5,
        OP_READ_ID    = 3'd6,
        OP_SPARE      = 3'd7
    } op_e;

    // ext_lock is lock bit 1, read_lock is lock bit 2; 1 = programmed
    typedef struct packed {
        logic read_lock;
        logic ext_lock;
    } lock_t;

    function automatic logic is_prog(input op_e op);
        return (op == OP_PROG_CODE) || (op == OP_PROG_KEY) ||
               (op == OP_PROG_LOCK1) || (op == OP_PROG_LOCK2);
    endfunction

    function automatic logic [7:0] scramble(input logic [7:0] code, input logic [7:0] key);
        return ~(code ^ key);
    endfunction

    function automatic logic [7:0] id_byte(input logic [15:0] a);
        if (a == ID_ADDR_LO) return ID_BYTE_LO;
        if (a == ID_ADDR_HI) return ID_BYTE_HI;
        return BLANK;
    endfunction

    function automatic logic any_lock(input lock_t l);
        return l.ext_lock | l.read_lock;
    endfunction

endpackage

// File: rtl/prom_guard_strobe.sv
module prom_guard_strobe
    import prom_guard_pkg::*;
#(
    parameter int LOW_MIN  = 100,
    parameter int HIGH_MIN = 10,
    parameter int PULSES   = 25
) (
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  logic prog_n,
    output logic fire
);
    localparam int LW = $clog2(LOW_MIN + 1);
    localparam int HW = $clog2(HIGH_MIN + 1);
    localparam int PW = $clog2(PULSES + 1);
    localparam logic [LW-1:0] LO_LIM = LW'(LOW_MIN);
    localparam logic [HW-1:0] HI_LIM = HW'(HIGH_MIN);
    localparam logic [PW-1:0] P_LAST = PW'(PULSES - 1);

    logic          prev_n;
    logic [LW-1:0] cnt_lo;
    logic [HW-1:0] cnt_hi;
    logic [PW-1:0] pulses;
    logic          gap_ok;
    logic          fire_q;
    op_e           op_q;
    logic          restart;

    assign restart = rst || !is_prog(op) || (op != op_q);

    always_ff @(posedge clk) begin
        if (rst) op_q <= OP_IDLE;
        else     op_q <= op;
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            prev_n <= 1'b1;
            cnt_lo <= '0;
            cnt_hi <= '0;
            pulses <= '0;
            gap_ok <= 1'b0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            prev_n <= prog_n;
            if (!prog_n) begin
                cnt_hi <= '0;
                if (cnt_lo < LO_LIM) cnt_lo <= cnt_lo + 1'b1;
                if (prev_n) gap_ok <= (cnt_hi >= HI_LIM);
            end else begin
                cnt_lo <= '0;
                if (cnt_hi < HI_LIM) cnt_hi <= cnt_hi + 1'b1;
                if (!prev_n && gap_ok && (cnt_lo >= LO_LIM)) begin
                    if (pulses == P_LAST) begin
                        pulses <= '0;
                        fire_q <= 1'b1;
                    end else begin
                        pulses <= pulses + 1'b1;
                    end
                end
            end
        end
    end

    assign fire = fire_q;

endmodule

// File: rtl/prom_guard_policy.sv
module prom_guard_policy
    import prom_guard_pkg::*;
#(
    parameter int ADDR_W = PG_ADDR_W,
    parameter int KEYS   = PG_KEYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uv_erase,
    input  logic              fire,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_access,
    output lock_t             lock,
    output logic              wr_code,
    output logic              wr_key,
    output logic              ea_eff,
    output logic              ext_fetch_deny,
    output logic              err
);
    localparam int KIW = $clog2(KEYS);

    lock_t lock_q;
    logic  ea_hold;
    logic  err_q;
    logic  locked;
    logic  key_out_of_range;
    logic  refuse;
    logic  verify_blocked;

    assign locked           = any_lock(lock_q);
    assign key_out_of_range = (addr[ADDR_W-1:KIW] != '0);
    assign refuse = fire && (((op == OP_PROG_CODE) || (op == OP_PROG_KEY)) && locked ||
                             (op == OP_PROG_KEY) && key_out_of_range);
    assign verify_blocked = (op == OP_VERIFY) && lock_q.ext_lock && lock_q.read_lock;

    assign wr_code = fire && (op == OP_PROG_CODE) && !locked;
    assign wr_key  = fire && (op == OP_PROG_KEY) && !locked && !key_out_of_range;

    // lock bits are non-volatile: only erase clears them
    always_ff @(posedge clk) begin
        if (uv_erase) begin
            lock_q <= '0;
        end else if (fire) begin
            if (op == OP_PROG_LOCK1) lock_q.ext_lock  <= 1'b1;
            if (op == OP_PROG_LOCK2) lock_q.read_lock <= 1'b1;
        end
    end

    // strap level captured on every reset cycle, used while lock bit 1 is set
    always_ff @(posedge clk) begin
        if (rst) ea_hold <= ext_access;
    end

    always_ff @(posedge clk) begin
        if (rst)                          err_q <= 1'b0;
        else if (refuse || verify_blocked) err_q <= 1'b1;
    end

    assign lock           = lock_q;
    assign ea_eff         = lock_q.ext_lock ? ea_hold : ext_access;
    assign ext_fetch_deny = lock_q.ext_lock;
    assign err            = err_q;

endmodule

// File: rtl/prom_guard_store.sv
module prom_guard_store
    import prom_guard_pkg::*;
#(
    parameter int ADDR_W = PG_ADDR_W,
    parameter int DATA_W = PG_DATA_W,
    parameter int KEYS   = PG_KEYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uv_erase,
    input  logic              wr_code,
    input  logic              wr_key,
    input  op_e               op,
    input  lock_t             lock,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int KIW   = $clog2(KEYS);

    logic [DATA_W-1:0] code_mem [DEPTH];
    logic [DATA_W-1:0] key_mem  [KEYS];
    logic [DATA_W-1:0] dout_q;
    logic [KIW-1:0]    kidx;

    assign kidx = addr[KIW-1:0];

    always_ff @(posedge clk) begin
        if (uv_erase) begin
            for (int i = 0; i < DEPTH; i++) code_mem[i] <= '1;
            for (int k = 0; k < KEYS; k++)  key_mem[k]  <= '1;
        end else begin
            if (wr_code) code_mem[addr] <= din;
            if (wr_key)  key_mem[kidx]  <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '1;
        end else begin
            unique case (op)
                OP_VERIFY:
                    if (lock.ext_lock && lock.read_lock) dout_q <= '1;
                    else dout_q <= scramble(code_mem[addr], key_mem[kidx]);
                OP_READ_ID: dout_q <= id_byte(16'(addr));
                default:    dout_q <= '1;
            endcase
        end
    end

    assign dout = dout_q;

endmodule

// File: rtl/prom_guard.sv
module prom_guard
    import prom_guard_pkg::*;
#(
    parameter int ADDR_W   = PG_ADDR_W,
    parameter int DATA_W   = PG_DATA_W,
    parameter int KEYS     = PG_KEYS,
    parameter int LOW_MIN  = 100,
    parameter int HIGH_MIN = 10,
    parameter int PULSES   = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uv_erase,
    input  logic [2:0]        op_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              prog_n,
    input  logic              ext_access,
    output logic [DATA_W-1:0] dout,
    output logic              ea_eff,
    output logic              ext_fetch_deny,
    output logic              err
);
    op_e   op;
    logic  fire;
    logic  wr_code;
    logic  wr_key;
    lock_t lock_q;

    assign op = op_e'(op_sel);

    prom_guard_strobe #(
        .LOW_MIN (LOW_MIN),
        .HIGH_MIN(HIGH_MIN),
        .PULSES  (PULSES)
    ) u_strobe (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .prog_n(prog_n),
        .fire  (fire)
    );

    prom_guard_policy #(
        .ADDR_W(ADDR_W),
        .KEYS  (KEYS)
    ) u_policy (
        .clk           (clk),
        .rst           (rst),
        .uv_erase      (uv_erase),
        .fire          (fire),
        .op            (op),
        .addr          (addr),
        .ext_access    (ext_access),
        .lock          (lock_q),
        .wr_code       (wr_code),
        .wr_key        (wr_key),
        .ea_eff        (ea_eff),
        .ext_fetch_deny(ext_fetch_deny),
        .err           (err)
    );

    prom_guard_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .KEYS  (KEYS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .uv_erase(uv_erase),
        .wr_code (wr_code),
        .wr_key  (wr_key),
        .op      (op),
        .lock    (lock_q),
        .addr    (addr),
        .din     (din),
        .dout    (dout)
    );

endmodule

// File: rtl/prom_guard_chk.sv
module prom_guard_chk
    import prom_guard_pkg::*;
#(
    parameter int ADDR_W = PG_ADDR_W,
    parameter int DATA_W = PG_DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              uv_erase,
    input logic [2:0]        op_sel,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout,
    input logic              err,
    input logic              ea_eff,
    input logic              fire,
    input lock_t             lock
);
    localparam int KIW = $clog2(PG_KEYS);

    p_fire_single_r3: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    p_key_range_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && op_sel == 3'd3 && addr[ADDR_W-1:KIW] != '0) |=> err);

    p_refuse_err_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && (op_sel == 3'd1 || op_sel == 3'd3) && (lock.ext_lock || lock.read_lock)) |=> err);

    p_verify_block_r9: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd2 && lock.ext_lock && lock.read_lock) |=> (dout == 8'hFF && err));

    p_id_lo_r10: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd6 && addr == ADDR_W'(12'h030)) |=> dout == 8'h89);

    p_id_hi_r10: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd6 && addr == ADDR_W'(12'h031)) |=> dout == 8'h57);

    p_ea_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (lock.ext_lock && $past(lock.ext_lock) && !$past(rst)) |-> $stable(ea_eff));

    p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    p_lock_kept_r12: assert property (@(posedge clk) disable iff (rst)
        (lock.ext_lock && !uv_erase) |=> lock.ext_lock);

endmodule

bind prom_guard prom_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .uv_erase(uv_erase),
    .op_sel  (op_sel),
    .addr    (addr),
    .dout    (dout),
    .err     (err),
    .ea_eff  (ea_eff),
    .fire    (fire),
    .lock    (lock_q)
);

// File: tb/prom_guard_tb.sv
module prom_guard_tb;

    localparam int LOW_MIN  = 8;
    localparam int HIGH_MIN = 4;
    localparam int LOWC  = 10;
    localparam int SHORT = 7;
    localparam int GAP   = 6;
    localparam int SGAP  = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uv_erase = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [11:0] addr = '0;
    logic [7:0] din = '0;
    logic       prog_n = 1'b1;
    logic       ext_access = 1'b0;
    logic [7:0] dout;
    logic       ea_eff, ext_fetch_deny, err;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] m_code [4096];
    logic [7:0] m_key  [32];
    logic [1:0] m_lock;
    logic       m_err;
    logic       m_ea_hold;

    always #2 clk = ~clk;

    prom_guard #(.LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN), .PULSES(25)) u_dut (
        .clk(clk), .rst(rst), .uv_erase(uv_erase), .op_sel(op_sel), .addr(addr),
        .din(din), .prog_n(prog_n), .ext_access(ext_access), .dout(dout),
        .ea_eff(ea_eff), .ext_fetch_deny(ext_fetch_deny), .err(err)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_verify(input logic [11:0] a);
        if (m_lock == 2'b11) return 8'hFF;
        return ~(m_code[a] ^ m_key[a[4:0]]);
    endfunction

    function automatic logic [7:0] exp_id(input logic [11:0] a);
        if (a == 12'h030) return 8'h89;
        if (a == 12'h031) return 8'h57;
        return 8'hFF;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        op_sel = 3'd0;
        repeat (3) @(negedge clk);
        m_ea_hold = ext_access;
        rst = 1'b0;
        m_err = 1'b0;
    endtask

    task automatic erase();
        @(negedge clk);
        uv_erase = 1'b1;
        @(negedge clk);
        uv_erase = 1'b0;
        for (int i = 0; i < 4096; i++) m_code[i] = 8'hFF;
        for (int k = 0; k < 32; k++) m_key[k] = 8'hFF;
        m_lock = 2'b00;
    endtask

    task automatic pulse(input int lo, input int hi);
        prog_n = 1'b0;
        repeat (lo) @(negedge clk);
        prog_n = 1'b1;
        repeat (hi) @(negedge clk);
    endtask

    task automatic arm(input logic [2:0] op, input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        op_sel = op;
        addr = a;
        din = d;
        prog_n = 1'b1;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic model_prog(input logic [2:0] op, input logic [11:0] a, input logic [7:0] d);
        case (op)
            3'd1: if (m_lock != 2'b00) m_err = 1'b1; else m_code[a] = d;
            3'd3: if (m_lock != 2'b00 || a[11:5] != 7'd0) m_err = 1'b1; else m_key[a[4:0]] = d;
            3'd4: m_lock[0] = 1'b1;
            3'd5: m_lock[1] = 1'b1;
            default: ;
        endcase
    endtask

    task automatic prog(input logic [2:0] op, input logic [11:0] a, input logic [7:0] d);
        arm(op, a, d);
        repeat (25) pulse(LOWC, GAP);
        repeat (3) @(negedge clk);
        op_sel = 3'd0;
        model_prog(op, a, d);
    endtask

    task automatic rd(input logic [2:0] op, input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        op_sel = op;
        addr = a;
        @(negedge clk);
        d = dout;
        if (op == 3'd2 && m_lock == 2'b11) m_err = 1'b1;
    endtask

    task automatic chk_verify(input string tag, input logic [11:0] a);
        logic [7:0] v;
        rd(3'd2, a, v);
        chk(tag, v, exp_verify(a));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0]  v;
        logic [11:0] pa [8];
        logic [11:0] a;
        int unsigned s;
        s = $urandom(32'd2024);
        m_lock = 2'b00;
        m_err = 1'b0;

        do_reset();
        chk("R1 dout after reset", dout, 8'hFF);
        chk("R1 err after reset", {7'd0, err}, 8'd0);

        erase();
        for (int i = 0; i < 6; i++) chk_verify("R2 erased verify", 12'($urandom() % 4096));

        // random code and key writes
        for (int i = 0; i < 8; i++) begin
            pa[i] = 12'($urandom() % 4096);
            prog(3'd1, pa[i], 8'($urandom()));
        end
        for (int i = 0; i < 5; i++) prog(3'd3, 12'($urandom() % 32), 8'($urandom()));
        for (int i = 0; i < 8; i++) chk_verify("R6 verify programmed", pa[i]);
        for (int i = 0; i < 10; i++) chk_verify("R6 verify random", 12'($urandom() % 4096));
        chk("R3 no err after legal writes", {7'd0, err}, {7'd0, m_err});

        // directed: key entry 0 and matching code address
        prog(3'd3, 12'h000, 8'hA5);
        prog(3'd1, 12'h020, 8'h3C);
        chk_verify("R6 key index from low bits", 12'h020);

        // R3: 24 pulses then leave, nothing committed
        arm(3'd1, 12'h123, 8'h5A);
        repeat (24) pulse(LOWC, GAP);
        op_sel = 3'd0;
        chk_verify("R3 24 pulses no commit", 12'h123);

        // R4: 24 good pulses plus one short low
        arm(3'd1, 12'h124, 8'h11);
        repeat (24) pulse(LOWC, GAP);
        pulse(SHORT, GAP);
        repeat (3) @(negedge clk);
        op_sel = 3'd0;
        chk_verify("R4 short low not counted", 12'h124);

        // R4: 25th pulse after a short high gap
        arm(3'd1, 12'h125, 8'h22);
        repeat (23) pulse(LOWC, GAP);
        pulse(LOWC, SGAP);
        pulse(LOWC, GAP);
        repeat (3) @(negedge clk);
        op_sel = 3'd0;
        chk_verify("R4 short gap not counted", 12'h125);

        // R5: 20 pulses, switch op, 5 more
        arm(3'd1, 12'h126, 8'h33);
        repeat (20) pulse(LOWC, GAP);
        op_sel = 3'd3;
        @(negedge clk);
        op_sel = 3'd1;
        repeat (GAP) @(negedge clk);
        repeat (5) pulse(LOWC, GAP);
        repeat (3) @(negedge clk);
        op_sel = 3'd0;
        chk_verify("R5 op change clears count", 12'h126);

        // R3: full train commits
        prog(3'd1, 12'h126, 8'h33);
        chk_verify("R3 full train commits", 12'h126);

        // R7: key write out of range
        prog(3'd3, 12'h025, 8'h00);
        chk("R7 err on key range", {7'd0, err}, {7'd0, m_err});
        chk_verify("R7 key entry unchanged", 12'h005);

        // R12: reset clears err, keeps contents
        do_reset();
        chk("R12 err cleared by reset", {7'd0, err}, 8'd0);
        chk_verify("R12 contents survive reset", 12'h126);
        chk_verify("R12 contents survive reset", 12'h020);

        // R10 identification bytes
        rd(3'd6, 12'h030, v); chk("R10 id low", v, exp_id(12'h030));
        rd(3'd6, 12'h031, v); chk("R10 id high", v, exp_id(12'h031));
        rd(3'd6, 12'h032, v); chk("R10 id other", v, exp_id(12'h032));

        // R11 before lock: strap follows pin
        @(negedge clk); ext_access = 1'b1; #1;
        chk("R11 ea follows pin", {7'd0, ea_eff}, 8'd1);
        chk("R11 no deny unlocked", {7'd0, ext_fetch_deny}, 8'd0);
        ext_access = 1'b0; #1;
        chk("R11 ea follows pin low", {7'd0, ea_eff}, 8'd0);

        // lock bit 1
        prog(3'd4, 12'h000, 8'h00);
        chk("R11 deny with lock1", {7'd0, ext_fetch_deny}, 8'd1);
        ext_access = 1'b1;
        do_reset();
        @(negedge clk); ext_access = 1'b0; #1;
        chk("R11 ea latched high", {7'd0, ea_eff}, {7'd0, m_ea_hold});
        do_reset();
        @(negedge clk); ext_access = 1'b1; #1;
        chk("R11 ea latched low", {7'd0, ea_eff}, {7'd0, m_ea_hold});

        // R8 refused writes under lock1
        a = pa[0];
        prog(3'd1, a, ~m_code[a]);
        chk("R8 code write refused err", {7'd0, err}, {7'd0, m_err});
        chk_verify("R8 code unchanged", a);
        prog(3'd3, 12'h000, 8'h00);
        chk_verify("R8 key unchanged", 12'h020);
        chk_verify("R8 verify allowed with lock1", 12'h126);

        // R9 lock bit 2 still accepted, verify blocked
        do_reset();
        prog(3'd5, 12'h000, 8'h00);
        chk_verify("R9 verify blocked", 12'h126);
        chk("R9 err on blocked verify", {7'd0, err}, {7'd0, m_err});

        // R2 erase clears locks
        erase();
        chk("R2 locks cleared", {7'd0, ext_fetch_deny}, 8'd0);
        chk_verify("R2 verify erased", 12'h126);
        chk_verify("R2 verify erased", 12'h020);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule